// File: doc/BRIEF.md
# Filtered-Sample Capture FIFO with Interrupt Combining

This block sits after a filter stage that produces one unsigned sample word per strobe. Every sample lands in a latest-value register that software can read at any time without disturbing it. The same sample is also appended to an eight-entry first-in first-out store. Software drains that store through a pop strobe, and it can read the current fill count first so that it knows how many entries are valid.

Three sticky status flags record events: a new sample arrived, the fill count reached a programmed level, or a sample was dropped because the store was full. Each flag has its own enable. The enabled flags are ORed together, and the result reaches the interrupt output only when both the module enable and the global enable are set. Software clears each flag by writing a one to its clear strobe.

Top module: `fsamp_fifo_irq`

## Requirements
- R1: After reset, `fill_cnt`, `pop_data`, `latest_data`, all three flags and `irq` are 0. `fill_cnt` never exceeds 8. An accepted sample adds one to it and a successful pop subtracts one, both at the next clock edge.
- R2: A pop while `fill_cnt` is not zero removes the oldest entry. That entry appears on `pop_data` from the clock edge that follows, so entries come out in arrival order.
- R3: A pop while `fill_cnt` is 0 leaves `fill_cnt` at 0 and leaves `pop_data` holding the last value it showed.
- R4: `latest_data` takes the value of `smp_data` at the edge after each `smp_valid`, whether or not the FIFO accepts the sample. Pops do not change it.
- R5: `rdy_flag` is set at the edge after each `smp_valid` and stays set until a `clr_rdy` pulse. When a set and a clear fall in the same cycle, the set wins.
- R6: `lvl_flag` is set at the edge where `fill_cnt` changes to a value equal to a nonzero `level_cfg`. It is sticky and is cleared by `clr_lvl`, with set winning over clear.
- R7: While `level_cfg` is 0, `lvl_flag` never gets set.
- R8: A sample that arrives while `fill_cnt` is 8 and no pop is made in the same cycle is discarded. The stored entries stay as they were and `ovf_flag` is set. `ovf_flag` is sticky until `clr_ovf`, with set winning over clear.
- R9: A sample and a pop in the same cycle on a full FIFO are both carried out. `fill_cnt` stays 8 and `ovf_flag` is not set.
- R10: `irq` equals `glb_ie & mod_ie & ((rdy_flag & rdy_ie) | (lvl_flag & lvl_ie) | (ovf_flag & ovf_ie))`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | New filtered sample strobe |
| smp_data | input | 16 | Filtered sample, unsigned |
| latest_data | output | 16 | Most recent sample |
| pop | input | 1 | FIFO pop strobe |
| pop_data | output | 16 | Last popped entry |
| fill_cnt | output | 4 | Entries held, 0 to 8 |
| level_cfg | input | 4 | Level-match value, 0 disables |
| rdy_ie | input | 1 | Data-ready interrupt enable |
| lvl_ie | input | 1 | Level interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| mod_ie | input | 1 | Module interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| clr_rdy | input | 1 | Write-one-to-clear for the ready flag |
| clr_lvl | input | 1 | Write-one-to-clear for the level flag |
| clr_ovf | input | 1 | Write-one-to-clear for the overflow flag |
| rdy_flag | output | 1 | Data-ready status |
| lvl_flag | output | 1 | Level-match status |
| ovf_flag | output | 1 | Overflow status |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that the fill count stays within bounds, that an empty pop freezes both the count and the output, and that a drop on a full store freezes the count and the write position. They also check that a full store doing a sample and a pop together stays at eight, that the ready and overflow flags set and hold, that a zero level never sets the level flag, and that the interrupt stays low without both outer enables. The data order through the store, the stale value after an empty pop, and exact level matching across many fill patterns can only be shown by the bench. It runs a queue-based reference model against the block on every clock, through directed scenarios and then a long stretch of random traffic.

// File: rtl/fsamp_pkg.sv
package fsamp_pkg;

  // Fill count after one cycle: accepted push adds, successful pop removes.
  function automatic int next_fill(int cur, bit accepted, bit popped);
    return cur + int'(accepted) - int'(popped);
  endfunction

  // Level event: the count moves onto a nonzero programmed level.
  function automatic bit level_hit(int level, int cur, int nxt);
    return (level != 0) && (nxt == level) && (cur != level);
  endfunction

endpackage

// File: rtl/fsamp_store.sv
module fsamp_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [CNT_W-1:0]  fill_o,
  output logic [CNT_W-1:0]  fill_nxt_o,
  output logic [DATA_W-1:0] head_o,
  output logic              drop_o
);
  import fsamp_pkg::*;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  fill_q;
  logic [DATA_W-1:0] head_q;

  // Named internal events
  logic full, pop_ok, accept;
  assign full   = (fill_q == CNT_W'(DEPTH));
  assign pop_ok = pop_i && (fill_q != '0);
  assign accept = push_i && (!full || pop_ok);
  assign drop_o = push_i && !accept;

  assign fill_nxt_o = CNT_W'(next_fill(int'(fill_q), accept, pop_ok));

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (accept && (wr_ptr == PTR_W'(g))) mem[g] <= data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_q <= '0;
      head_q <= '0;
    end else begin
      fill_q <= fill_nxt_o;
      if (accept) wr_ptr <= bump(wr_ptr);
      if (pop_ok) begin
        rd_ptr <= bump(rd_ptr);
        head_q <= mem[rd_ptr];
      end
    end
  end

  assign fill_o = fill_q;
  assign head_o = head_q;

  // R1: count bounded by depth
  a_r1_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(DEPTH));
  // R3: empty pop changes nothing visible
  a_r3_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == '0 && pop_i && !push_i) |=> (fill_q == '0 && $stable(head_q)));
  // R8: dropped sample leaves count and write position alone
  a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_i && !pop_i) |=> (fill_q == CNT_W'(DEPTH) && $stable(wr_ptr)));
  // R9: push and pop together on a full store keep it full
  a_r9_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_i && pop_i) |=> (fill_q == CNT_W'(DEPTH)));

endmodule

// File: rtl/fsamp_flags.sv
module fsamp_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_i,
  input  logic lvl_hit_i,
  input  logic drop_i,
  input  logic clr_rdy_i,
  input  logic clr_lvl_i,
  input  logic clr_ovf_i,
  input  logic rdy_ie_i,
  input  logic lvl_ie_i,
  input  logic ovf_ie_i,
  input  logic mod_ie_i,
  input  logic glb_ie_i,
  output logic rdy_o,
  output logic lvl_o,
  output logic ovf_o,
  output logic irq_o
);
  logic [2:0] set_v, clr_v, ie_v, flag_q;

  assign set_v = {drop_i, lvl_hit_i, sample_i};
  assign clr_v = {clr_ovf_i, clr_lvl_i, clr_rdy_i};
  assign ie_v  = {ovf_ie_i, lvl_ie_i, rdy_ie_i};

  for (genvar i = 0; i < 3; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= set_v[i] | (flag_q[i] & ~clr_v[i]);
    end
  end

  logic any_req;
  assign any_req = |(flag_q & ie_v);
  assign irq_o   = any_req & mod_ie_i & glb_ie_i;

  assign rdy_o = flag_q[0];
  assign lvl_o = flag_q[1];
  assign ovf_o = flag_q[2];

  // R5: a sample always leaves the ready flag set
  a_r5_rdy_set: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i |=> rdy_o);
  // R8: overflow flag holds until cleared
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !clr_ovf_i) |=> ovf_o);
  // R8: a drop sets the overflow flag
  a_r8_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    drop_i |=> ovf_o);
  // R10: no request escapes without both outer enables
  a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !(mod_ie_i && glb_ie_i) |-> !irq_o);

endmodule

// File: rtl/fsamp_fifo_irq.sv
module fsamp_fifo_irq #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic [DATA_W-1:0] latest_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [CNT_W-1:0]  fill_cnt,
  input  logic [CNT_W-1:0]  level_cfg,
  input  logic              rdy_ie,
  input  logic              lvl_ie,
  input  logic              ovf_ie,
  input  logic              mod_ie,
  input  logic              glb_ie,
  input  logic              clr_rdy,
  input  logic              clr_lvl,
  input  logic              clr_ovf,
  output logic              rdy_flag,
  output logic              lvl_flag,
  output logic              ovf_flag,
  output logic              irq
);
  import fsamp_pkg::*;

  logic [CNT_W-1:0] fill_nxt;
  logic             drop_evt;
  logic             lvl_hit;
  logic [DATA_W-1:0] latest_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         latest_q <= '0;
    else if (smp_valid) latest_q <= smp_data;
  end
  assign latest_data = latest_q;

  fsamp_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (smp_valid),
    .data_i     (smp_data),
    .pop_i      (pop),
    .fill_o     (fill_cnt),
    .fill_nxt_o (fill_nxt),
    .head_o     (pop_data),
    .drop_o     (drop_evt)
  );

  assign lvl_hit = level_hit(int'(level_cfg), int'(fill_cnt), int'(fill_nxt));

  fsamp_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_i  (smp_valid),
    .lvl_hit_i (lvl_hit),
    .drop_i    (drop_evt),
    .clr_rdy_i (clr_rdy),
    .clr_lvl_i (clr_lvl),
    .clr_ovf_i (clr_ovf),
    .rdy_ie_i  (rdy_ie),
    .lvl_ie_i  (lvl_ie),
    .ovf_ie_i  (ovf_ie),
    .mod_ie_i  (mod_ie),
    .glb_ie_i  (glb_ie),
    .rdy_o     (rdy_flag),
    .lvl_o     (lvl_flag),
    .ovf_o     (ovf_flag),
    .irq_o     (irq)
  );

  // R4: latest register follows every sample
  a_r4_latest: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> (latest_data == $past(smp_data)));
  // R6: a level event leaves the level flag set
  a_r6_lvl_set: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_hit |=> lvl_flag);
  // R7: zero level never raises a clear level flag
  a_r7_lvl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (level_cfg == '0 && !lvl_flag) |=> !lvl_flag);

endmodule

// File: tb/tb_fsamp_fifo_irq.sv
module tb_fsamp_fifo_irq;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n = 0;
  logic smp_valid = 0, pop = 0;
  logic [15:0] smp_data = 0;
  logic [3:0]  level_cfg = 0;
  logic rdy_ie = 0, lvl_ie = 0, ovf_ie = 0, mod_ie = 0, glb_ie = 0;
  logic clr_rdy = 0, clr_lvl = 0, clr_ovf = 0;
  logic [15:0] latest_data, pop_data;
  logic [3:0]  fill_cnt;
  logic rdy_flag, lvl_flag, ovf_flag, irq;

  fsamp_fifo_irq dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string scen = "reset";

  // Reference model
  int q[$];
  int m_latest = 0, m_pd = 0;
  bit m_rdy = 0, m_lvl = 0, m_ovf = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0d expected=%0d t=%0t", tag, scen, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int m_irq;
    m_irq = (glb_ie && mod_ie && ((m_rdy && rdy_ie) || (m_lvl && lvl_ie) || (m_ovf && ovf_ie))) ? 1 : 0;
    chk("R1 fill", int'(fill_cnt), q.size());
    chk("R2 pop_data", int'(pop_data), m_pd);
    chk("R4 latest", int'(latest_data), m_latest);
    chk("R5 rdy", int'(rdy_flag), int'(m_rdy));
    chk("R6 lvl", int'(lvl_flag), int'(m_lvl));
    chk("R8 ovf", int'(ovf_flag), int'(m_ovf));
    chk("R10 irq", int'(irq), m_irq);
  endtask

  // Advance the model with the inputs held during the cycle just ended
  task automatic model_step();
    int old_n, new_n;
    bit pop_ok, acc;
    old_n = q.size();
    pop_ok = pop && old_n > 0;
    acc = smp_valid && (old_n < 8 || pop_ok);
    if (pop_ok) m_pd = q.pop_front();
    if (acc) q.push_back(int'(smp_data));
    new_n = q.size();
    if (smp_valid) m_latest = int'(smp_data);
    m_rdy = smp_valid || (m_rdy && !clr_rdy);
    m_lvl = (level_cfg != 0 && new_n == int'(level_cfg) && old_n != int'(level_cfg)) || (m_lvl && !clr_lvl);
    m_ovf = (smp_valid && !acc) || (m_ovf && !clr_ovf);
  endtask

  // Inputs are applied at a negedge; one cycle later results are compared
  task automatic cyc(bit v, int d, bit p);
    smp_valid = v; smp_data = 16'(d); pop = p;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    smp_valid = 0; pop = 0; clr_rdy = 0; clr_lvl = 0; clr_ovf = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    scen = "R1 reset state";
    compare_all();

    scen = "R2 order";
    cyc(1, 101, 0); cyc(1, 202, 0); cyc(1, 303, 0);
    cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 1);

    scen = "R3 empty pop stale";
    cyc(0, 0, 1); cyc(0, 0, 1);
    scen = "R3 empty pop with push";
    cyc(1, 404, 1); cyc(0, 0, 1);

    scen = "R5 clear and set-wins";
    clr_rdy = 1; cyc(0, 0, 0);
    clr_rdy = 1; cyc(1, 7, 0);
    cyc(0, 0, 1);

    scen = "R6 level 5 fill";
    level_cfg = 5; lvl_ie = 1; mod_ie = 1; glb_ie = 1;
    clr_lvl = 1; clr_rdy = 1; cyc(0, 0, 0);
    for (int i = 0; i < 8; i++) cyc(1, 1000 + i, 0);
    scen = "R8 overflow drop";
    ovf_ie = 1;
    cyc(1, 9999, 0); cyc(1, 8888, 0);
    scen = "R9 full swap";
    clr_ovf = 1; cyc(1, 5555, 1);
    cyc(1, 6666, 1);
    scen = "R10 gating";
    glb_ie = 0; cyc(0, 0, 0);
    glb_ie = 1; mod_ie = 0; cyc(0, 0, 0);
    mod_ie = 1; cyc(0, 0, 0);
    scen = "R6 level re-hit on drain";
    clr_lvl = 1; cyc(0, 0, 0);
    for (int i = 0; i < 9; i++) cyc(0, 0, 1);

    scen = "R7 level zero";
    level_cfg = 0; clr_lvl = 1; clr_ovf = 1; clr_rdy = 1; cyc(0, 0, 0);
    for (int i = 0; i < 10; i++) cyc(1, 2000 + i, 0);
    for (int i = 0; i < 9; i++) cyc(0, 0, 1);

    scen = "random traffic";
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) level_cfg = 4'($urandom_range(0, 8));
      rdy_ie = 1'($urandom); lvl_ie = 1'($urandom); ovf_ie = 1'($urandom);
      mod_ie = ($urandom_range(0, 3) != 0); glb_ie = ($urandom_range(0, 3) != 0);
      clr_rdy = ($urandom_range(0, 7) == 0);
      clr_lvl = ($urandom_range(0, 7) == 0);
      clr_ovf = ($urandom_range(0, 7) == 0);
      cyc(($urandom_range(0, 9) < 6), int'($urandom_range(0, 65535)),
          ($urandom_range(0, 9) < ((i / 300) % 2 == 0 ? 3 : 7)));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule